// File: doc/BRIEF.md
# Instruction-Cycle Prescaler With Per-Consumer Tap Selection

This block turns the oscillator clock into the timing references that a small controller's peripherals need. A six-phase counter marks the end of each instruction cycle, and a binary chain advances once per instruction cycle. Five consumers each pick one bit of that chain with their own 4-bit ratio code: timer A, timer B, the serial shifter, the converter control clock and a clock-output pin. The timers, the shifter and the converter get a single-cycle enable pulse. The pin gets a square wave.

The shared pin carries the serial clock when the serial interface is enabled, and the divided clock output otherwise. The converter control enable can instead follow an external clock input. That input is synchronised into the oscillator domain and edge-detected. The timers, the serial shifter and the converter themselves live outside this block.

Top module: `cyc_presc_top`

## Requirements
- R1: One instruction cycle is 6 oscillator clocks. With ratio code 1, the first timer A pulse appears 6 clocks after reset release, and the pulses then repeat every 12 clocks.
- R2: Ratio code n, for n from 1 to 12, gives a pulse every 6·2^n oscillator clocks. The first pulse comes 6·2^(n-1) clocks after reset release, and a pulse always follows directly on an instruction-cycle boundary.
- R3: Ratio codes 0, 13, 14 and 15 behave exactly like code 1 (divide by 2).
- R4: Every enable output is high for one oscillator clock at a time, on the rising edge of its selected chain bit, provided its code is held.
- R5: The five ratio codes act independently. Each output follows only its own code.
- R6: With ser_en = 1, clk_pin is the serial tap bit: a square wave with period 6·2^n clocks, high for the second half. At code 1 it runs at one twelfth of the oscillator rate. It changes only right after an instruction-cycle boundary.
- R7: With ser_en = 0, clk_pin is the same kind of square wave, built from the clock-output code.
- R8: With adc_ext_sel = 1, adc_tick pulses for one clock when a rising edge of adc_ext_clk comes out of a two-stage synchroniser. The pulse appears in the cycle after the second sampling edge at which the input is high.
- R9: While rst_n is low, every output is 0, and the phase counter and chain restart from zero.
- R10: With adc_ext_sel = 0, adc_ext_clk has no effect. With adc_ext_sel = 1, adc_code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_code | input | 4 | Timer A ratio code |
| t2_code | input | 4 | Timer B ratio code |
| sio_code | input | 4 | Serial shift clock ratio code |
| adc_code | input | 4 | Converter control clock ratio code |
| cko_code | input | 4 | Clock-output pin ratio code |
| ser_en | input | 1 | 1: pin carries the serial clock; 0: the divided clock output |
| adc_ext_sel | input | 1 | 1: converter enable follows adc_ext_clk |
| adc_ext_clk | input | 1 | External converter clock, asynchronous |
| t1_tick | output | 1 | Timer A count enable |
| t2_tick | output | 1 | Timer B count enable |
| sio_tick | output | 1 | Serial shift enable |
| adc_tick | output | 1 | Converter control enable |
| clk_pin | output | 1 | Shared pin square wave |

## Verification
The embedded assertions check on every cycle that:
- the phase stays within its six states;
- the chain moves only after an instruction-cycle boundary;
- no enable repeats in back-to-back cycles while its code is held;
- prescaler-driven pulses and pin transitions fall just after a boundary.

Only the bench's scenarios show the exact periods and first-pulse positions for each code, the fallback of the invalid codes, the pin source swap, and the synchroniser latency of the external converter clock. The bench shows these by comparing every output against a behavioural model on every clock, across three code sets that reach the deepest tap.

// File: rtl/cyc_presc_pkg.sv
package cyc_presc_pkg;

    // Source routed to the shared clock pin
    typedef enum logic {
        PIN_DIVOUT = 1'b0,
        PIN_SERCLK = 1'b1
    } pin_src_e;

    // Map a ratio code to a chain bit index; out-of-range codes fall back to bit 0
    function automatic int tap_index(input int code, input int stages);
        if (code >= 1 && code <= stages) begin
            return code - 1;
        end
        return 0;
    endfunction

endpackage

// File: rtl/cyc_presc_core.sv
module cyc_presc_core #(
    parameter int PHASES = 6,
    parameter int STAGES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] chain,
    output logic              cyc_end
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [STAGES-1:0] pre;
    } core_s;

    core_s core_d, core_q;

    always_comb begin
        core_d  = core_q;
        cyc_end = (int'(core_q.phase) == PHASES - 1);
        if (cyc_end) begin
            core_d.phase = '0;
            core_d.pre   = core_q.pre + 1'b1;
        end else begin
            core_d.phase = core_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign chain = core_q.pre;

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(core_q.phase) < PHASES);

    // R2
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.pre != $past(core_q.pre)) |-> (int'($past(core_q.phase)) == PHASES - 1));

endmodule

// File: rtl/cyc_presc_tap.sv
module cyc_presc_tap
    import cyc_presc_pkg::*;
#(
    parameter int STAGES = 12,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] chain,
    input  logic [CODE_W-1:0] code,
    output logic              level,
    output logic              tick
);
    localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    typedef struct packed {
        logic prev;
    } tap_s;

    tap_s tap_d, tap_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = IDX_W'(tap_index(int'(code), STAGES));
        level = chain[idx];
        tick  = level & ~tap_q.prev;
        tap_d = tap_q;
        tap_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_d;
        end
    end

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || !$stable(code)));

endmodule

// File: rtl/cyc_presc_sync.sv
module cyc_presc_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [SYNC:0] sh;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[SYNC-1:0], async_in};
        rise      = sync_q.sh[SYNC-1] & ~sync_q.sh[SYNC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cyc_presc_top.sv
module cyc_presc_top
    import cyc_presc_pkg::*;
#(
    parameter int PHASES = 6,
    parameter int STAGES = 12,
    parameter int CODE_W = 4,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] t1_code,
    input  logic [CODE_W-1:0] t2_code,
    input  logic [CODE_W-1:0] sio_code,
    input  logic [CODE_W-1:0] adc_code,
    input  logic [CODE_W-1:0] cko_code,
    input  logic              ser_en,
    input  logic              adc_ext_sel,
    input  logic              adc_ext_clk,
    output logic              t1_tick,
    output logic              t2_tick,
    output logic              sio_tick,
    output logic              adc_tick,
    output logic              clk_pin
);
    localparam int USERS = 5;
    localparam int U_T1  = 0;
    localparam int U_T2  = 1;
    localparam int U_SIO = 2;
    localparam int U_ADC = 3;
    localparam int U_CKO = 4;

    logic [STAGES-1:0]             chain;
    logic                          cyc_end;
    logic [USERS-1:0][CODE_W-1:0]  codes;
    logic [USERS-1:0]              lvl;
    logic [USERS-1:0]              tck;
    logic                          ext_rise;
    pin_src_e                      pin_src;

    assign codes = {cko_code, adc_code, sio_code, t2_code, t1_code};

    cyc_presc_core #(
        .PHASES (PHASES),
        .STAGES (STAGES)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .chain   (chain),
        .cyc_end (cyc_end)
    );

    for (genvar u = 0; u < USERS; u++) begin : g_tap
        cyc_presc_tap #(
            .STAGES (STAGES),
            .CODE_W (CODE_W)
        ) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .chain (chain),
            .code  (codes[u]),
            .level (lvl[u]),
            .tick  (tck[u])
        );
    end

    cyc_presc_sync #(
        .SYNC (SYNC)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (adc_ext_clk),
        .rise     (ext_rise)
    );

    always_comb begin
        pin_src  = ser_en ? PIN_SERCLK : PIN_DIVOUT;
        t1_tick  = tck[U_T1];
        t2_tick  = tck[U_T2];
        sio_tick = tck[U_SIO];
        adc_tick = adc_ext_sel ? ext_rise : tck[U_ADC];
        clk_pin  = (pin_src == PIN_SERCLK) ? lvl[U_SIO] : lvl[U_CKO];
    end

    // R2
    t1_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_tick && $stable(t1_code)) |-> $past(cyc_end));

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cyc_end) && $stable(ser_en) && $stable(sio_code) && $stable(cko_code))
            |-> $stable(clk_pin));

endmodule

// File: tb/cyc_presc_top_tb.sv
`timescale 1ns/1ps
module cyc_presc_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] t1_code = '0, t2_code = '0, sio_code = '0, adc_code = '0, cko_code = '0;
    logic       ser_en = 1'b0, adc_ext_sel = 1'b0, adc_ext_clk = 1'b0;
    logic       t1_tick, t2_tick, sio_tick, adc_tick, clk_pin;

    int errors = 0;
    int checks = 0;
    int k = 0;
    int smp0 = 0, smp1 = 0, smp2 = 0;
    int first_t1 = -1;
    int doubles = 0;
    bit drive_ext = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [3:0] prev_ticks = '0;
    string tag_tm;

    always #2 clk = ~clk;

    cyc_presc_top u_dut (
        .clk (clk), .rst_n (rst_n),
        .t1_code (t1_code), .t2_code (t2_code), .sio_code (sio_code),
        .adc_code (adc_code), .cko_code (cko_code),
        .ser_en (ser_en), .adc_ext_sel (adc_ext_sel), .adc_ext_clk (adc_ext_clk),
        .t1_tick (t1_tick), .t2_tick (t2_tick), .sio_tick (sio_tick),
        .adc_tick (adc_tick), .clk_pin (clk_pin)
    );

    // Behavioural model: selected chain bit after e edges since reset release
    function automatic int mbit(input int code, input int e);
        int idx;
        int p;
        idx = (code >= 1 && code <= 12) ? code - 1 : 0;
        if (e <= 0) return 0;
        p = (e / 6) % 4096;
        return (p >> idx) & 1;
    endfunction

    function automatic int mtick(input int code, input int e);
        return mbit(code, e) & (1 - mbit(code, e - 1));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, k, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        adc_ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        // R9
        chk("R9", "t1_tick in reset", int'(t1_tick), 0);
        chk("R9", "t2_tick in reset", int'(t2_tick), 0);
        chk("R9", "sio_tick in reset", int'(sio_tick), 0);
        chk("R9", "adc_tick in reset", int'(adc_tick), 0);
        chk("R9", "clk_pin in reset", int'(clk_pin), 0);
        k = 0; smp0 = 0; smp1 = 0; smp2 = 0;
        prev_ticks = '0;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, input string tag_t);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            k++;
            smp2 = smp1; smp1 = smp0; smp0 = int'(adc_ext_clk);
            @(negedge clk);
            chk(tag_t, "t1_tick", int'(t1_tick), mtick(int'(t1_code), k));
            chk(tag_t, "t2_tick", int'(t2_tick), mtick(int'(t2_code), k));
            chk(tag_t == "R3" ? "R3" : "R5", "sio_tick", int'(sio_tick), mtick(int'(sio_code), k));
            if (adc_ext_sel)
                chk("R8", "adc_tick ext", int'(adc_tick), smp1 & (1 - smp2));
            else
                chk("R10", "adc_tick presc", int'(adc_tick), mtick(int'(adc_code), k));
            if (ser_en)
                chk("R6", "clk_pin serial", int'(clk_pin), mbit(int'(sio_code), k));
            else
                chk("R7", "clk_pin divout", int'(clk_pin), mbit(int'(cko_code), k));
            if (t1_tick && first_t1 < 0) first_t1 = k;
            if ((prev_ticks & {adc_tick, sio_tick, t2_tick, t1_tick}) != 0 && !adc_ext_sel) doubles++;
            prev_ticks = {adc_tick, sio_tick, t2_tick, t1_tick};
            if (drive_ext) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[3:0] < 4'd5) adc_ext_clk = ~adc_ext_clk;
            end
        end
    endtask

    initial begin
        // Scenario A: valid codes, serial pin, prescaled converter clock
        t1_code = 4'd1; t2_code = 4'd3; sio_code = 4'd2; adc_code = 4'd12; cko_code = 4'd5;
        ser_en = 1'b1; adc_ext_sel = 1'b0; drive_ext = 0;
        do_reset();
        first_t1 = -1;
        tag_tm = "R2";
        run(26000, tag_tm);
        // R1: first timer A pulse six clocks after reset release
        chk("R1", "first t1 pulse edge", first_t1, 6);
        // R4: no enable held for two cycles
        chk("R4", "back-to-back pulses", doubles, 0);

        // Scenario B: fallback codes, divided output on pin, external clock ignored
        t1_code = 4'd0; t2_code = 4'd13; sio_code = 4'd15; adc_code = 4'd4; cko_code = 4'd12;
        ser_en = 1'b0; adc_ext_sel = 1'b0; drive_ext = 1;
        do_reset();
        first_t1 = -1;
        run(13000, "R3");
        chk("R3", "first t1 pulse edge code 0", first_t1, 6);

        // Scenario C: external converter clock, adc_code ignored
        t1_code = 4'd2; t2_code = 4'd6; sio_code = 4'd1; adc_code = 4'd1; cko_code = 4'd1;
        ser_en = 1'b1; adc_ext_sel = 1'b1; drive_ext = 1;
        do_reset();
        run(3000, "R5");
        chk("R4", "back-to-back pulses total", doubles, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at edge %0d: actual=running expected=done", k);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule